// File: doc/BRIEF.md
# Sink capability and EDID fetcher

This block runs the discovery sequence that comes before display link setup. After a start pulse it reads the sink's capability header from the configuration register space. It checks the header's revision, maximum link rate and maximum lane count. It then reads the extension count from the display-ID device and fetches one or two 128-byte EDID blocks, checking the checksum of each. Last, it services a pending sink test request by echoing the checksum byte of the final block it fetched.

Every transaction goes through one generic byte-access port. A request carries a kind, a device address, a byte address, a length and one write byte, and is held until it is accepted. Responses come back one byte per beat. Each beat carries a fail flag, and a failed beat ends the transfer. Once the sequence finishes, the block holds the accepted link-rate code, the lane count and the enhanced-framing capability, together with a done or error status and a fault code.

Top module: `sink_cap_fetch`

## Requirements
- R1: After reset, done, err, err_code, link_rate, lane_count, enh_frame and req_valid are all 0.
- R2: The first request is a configuration read (kind 0) at address 0 with length 12. A failed response causes the read to be requested again, up to CAP_TRIES attempts in total (default 5). If every attempt fails, the sequence ends with err=1 and err_code=1.
- R3: Header byte 0 (the revision) must be 0x10 or 0x11, otherwise err_code=2. Header byte 1 (the link rate) must be 0x06 or 0x0A, otherwise err_code=3. The revision is checked first.
- R4: For revision 0x11, lane_count is header byte 2 bits [4:0] and enh_frame is bit 7 of that byte. For revision 0x10, the whole byte 2 is the lane count and enh_frame is 0. A lane count other than 1, 2 or 4 gives err_code=4.
- R5: After the header is accepted, the block issues a display-ID read (kind 2) to device 0x50 at offset 126 with length 1. If that byte is non-zero, two block reads follow: offset 0 and then offset 128, each of length 128. Otherwise only the offset-0 read is issued.
- R6: The 8-bit wrapping sum of the 128 bytes of each block must be 0, otherwise the sequence ends with err_code=5. A failed response on any request after the header read ends the sequence with err_code=1.
- R7: After the blocks are fetched, the block reads configuration address 0x218 with length 1. If bit 2 of that byte is set, it writes (kind 1, length 1) the last byte of the last fetched block to address 0x261, then writes 0x04 to address 0x260. If bit 2 is clear, no write is issued. The sequence then ends with done=1.
- R8: A request's fields stay stable while req_valid is high and req_ready is low. After a request is accepted, no new request is raised until the last response beat of the current one.
- R9: done and err are never both high. Each holds until the next start. A start pulse while a sequence is running has no effect. A start from idle, done or error clears the outputs and begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a discovery sequence |
| req_valid | output | 1 | Request pending |
| req_ready | input | 1 | Request accepted this cycle |
| req_kind | output | 2 | 0 config read, 1 config write, 2 display-ID read |
| req_dev | output | 7 | Display-ID device address (0 for config access) |
| req_addr | output | ADDR_W | Byte address or offset |
| req_len | output | LEN_W | Number of bytes |
| req_wdata | output | 8 | Write byte |
| rsp_valid | input | 1 | Response beat |
| rsp_data | input | 8 | Response byte |
| rsp_fail | input | 1 | Beat reports a failed access and ends the transfer |
| link_rate | output | 8 | Accepted link-rate code |
| lane_count | output | 5 | Accepted lane count |
| enh_frame | output | 1 | Enhanced framing supported |
| done | output | 1 | Sequence finished without error |
| err | output | 1 | Sequence ended in error |
| err_code | output | 3 | 1 access, 2 revision, 3 link rate, 4 lane count, 5 checksum |

## Verification
The bench builds the block with its default parameters: 5 header attempts, 128-byte blocks, 8-bit lengths and 12-bit addresses. With those values it can make exactly four or five header reads fail and observe both sides of the retry limit. The full-size blocks place the checksum byte at offset 127 and the extension count at offset 126, so the bench's sink model can corrupt a byte in either block. A model that answers each request kind from its own tables makes each revision-dependent lane decode reachable, and also the test-request echo with the flag bit set and clear.

// File: rtl/sink_cap_pkg.sv
package sink_cap_pkg;

   typedef enum logic [1:0] {
      KIND_CFG_RD = 2'd0,
      KIND_CFG_WR = 2'd1,
      KIND_ID_RD  = 2'd2
   } acc_kind_t;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_ACCESS = 3'd1,
      FLT_REV    = 3'd2,
      FLT_RATE   = 3'd3,
      FLT_LANES  = 3'd4,
      FLT_CKSUM  = 3'd5
   } fault_t;

   typedef enum logic [2:0] {
      PH_CAP, PH_EXT, PH_BLK0, PH_BLK1, PH_TREQ, PH_TCS, PH_TRSP
   } phase_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_REQ, ST_WAIT, ST_EVAL, ST_DONE, ST_FAULT
   } state_t;

endpackage

// File: rtl/sink_cap_rx.sv
module sink_cap_rx
   import sink_cap_pkg::*;
#(
   parameter int LEN_W     = 8,
   parameter int HDR_BYTES = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clr,
   input  logic                           active,
   input  logic                           cap_en,
   input  logic [LEN_W-1:0]               exp_len,
   input  logic                           rsp_valid,
   input  logic [7:0]                     rsp_data,
   input  logic                           rsp_fail,
   output logic                           xfer_end,
   output logic                           xfer_fail,
   output logic [7:0]                     sum_next,
   output logic [HDR_BYTES-1:0][7:0]      hdr
);

   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

   logic [LEN_W-1:0] beat_cnt;
   logic [7:0]       sum_q;
   logic             beat;
   logic             good_beat;

   assign beat      = active & rsp_valid;
   assign good_beat = beat & ~rsp_fail;
   assign sum_next  = sum_q + rsp_data;
   assign xfer_fail = beat & rsp_fail;
   assign xfer_end  = beat & (rsp_fail | (beat_cnt == exp_len - LEN_ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_cnt <= '0;
         sum_q    <= '0;
      end else if (clr) begin
         beat_cnt <= '0;
         sum_q    <= '0;
      end else if (good_beat) begin
         beat_cnt <= beat_cnt + LEN_ONE;
         sum_q    <= sum_next;
      end
   end

   for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hdr[g] <= '0;
         else if (good_beat && cap_en && beat_cnt == LEN_W'(g))
            hdr[g] <= rsp_data;
      end
   end

endmodule

// File: rtl/sink_cap_decode.sv
module sink_cap_decode
   import sink_cap_pkg::*;
#(
   parameter logic [7:0] REV_OLD = 8'h10,
   parameter logic [7:0] REV_NEW = 8'h11,
   parameter logic [7:0] RATE_LO = 8'h06,
   parameter logic [7:0] RATE_HI = 8'h0A,
   parameter int         ENH_BIT = 7
) (
   input  logic [7:0] rev_byte,
   input  logic [7:0] rate_byte,
   input  logic [7:0] lane_byte,
   output fault_t     fault,
   output logic [4:0] lanes,
   output logic       enh
);

   logic [7:0] lane_val;
   logic       rev_ok;
   logic       rate_ok;
   logic       lane_ok;

   always_comb begin
      if (rev_byte == REV_NEW) begin
         lane_val = {3'b000, lane_byte[4:0]};
         enh      = lane_byte[ENH_BIT];
      end else begin
         lane_val = lane_byte;
         enh      = 1'b0;
      end
   end

   assign rev_ok  = (rev_byte == REV_OLD) || (rev_byte == REV_NEW);
   assign rate_ok = (rate_byte == RATE_LO) || (rate_byte == RATE_HI);
   assign lane_ok = (lane_val == 8'd1) || (lane_val == 8'd2) || (lane_val == 8'd4);
   assign lanes   = lane_val[4:0];

   always_comb begin
      if (!rev_ok)       fault = FLT_REV;
      else if (!rate_ok) fault = FLT_RATE;
      else if (!lane_ok) fault = FLT_LANES;
      else               fault = FLT_NONE;
   end

endmodule

// File: rtl/sink_cap_seq.sv
module sink_cap_seq
   import sink_cap_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int LEN_W     = 8,
   parameter int CAP_LEN   = 12,
   parameter int CAP_TRIES = 5,
   parameter int BLOCK_LEN = 128,
   parameter int EXT_OFS   = 126,
   parameter int ID_DEV    = 'h50,
   parameter int TREQ_ADDR = 'h218,
   parameter int TCS_ADDR  = 'h261,
   parameter int TRSP_ADDR = 'h260,
   parameter int TREQ_BIT  = 2,
   parameter int TRSP_FLAG = 'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              req_valid,
   input  logic              req_ready,
   output acc_kind_t         req_kind,
   output logic [6:0]        req_dev,
   output logic [ADDR_W-1:0] req_addr,
   output logic [LEN_W-1:0]  req_len,
   output logic [7:0]        req_wdata,
   input  logic [7:0]        rsp_data,
   input  logic              xfer_end,
   input  logic              xfer_fail,
   input  logic [7:0]        sum_next,
   output logic              rx_clr,
   output logic              rx_active,
   output logic              rx_cap_en,
   input  fault_t            dec_fault,
   input  logic [7:0]        dec_rate,
   input  logic [4:0]        dec_lanes,
   input  logic              dec_enh,
   output logic [7:0]        link_rate,
   output logic [4:0]        lane_count,
   output logic              enh_frame,
   output logic              done,
   output logic              err,
   output fault_t            err_code
);

   localparam int TRY_W = $clog2(CAP_TRIES + 1);
   localparam logic [TRY_W-1:0] TRY_MAX = TRY_W'(CAP_TRIES);
   localparam logic [TRY_W-1:0] TRY_ONE = TRY_W'(1);

   state_t          state;
   phase_t          phase;
   logic [TRY_W-1:0] tries;
   logic            ext_more;
   logic [7:0]      cks_byte;

   // request fields follow the current phase
   always_comb begin
      req_kind  = KIND_CFG_RD;
      req_dev   = 7'd0;
      req_addr  = '0;
      req_len   = LEN_W'(1);
      req_wdata = 8'd0;
      case (phase)
         PH_CAP: begin
            req_len = LEN_W'(CAP_LEN);
         end
         PH_EXT: begin
            req_kind = KIND_ID_RD;
            req_dev  = 7'(ID_DEV);
            req_addr = ADDR_W'(EXT_OFS);
         end
         PH_BLK0: begin
            req_kind = KIND_ID_RD;
            req_dev  = 7'(ID_DEV);
            req_len  = LEN_W'(BLOCK_LEN);
         end
         PH_BLK1: begin
            req_kind = KIND_ID_RD;
            req_dev  = 7'(ID_DEV);
            req_addr = ADDR_W'(BLOCK_LEN);
            req_len  = LEN_W'(BLOCK_LEN);
         end
         PH_TREQ: begin
            req_addr = ADDR_W'(TREQ_ADDR);
         end
         PH_TCS: begin
            req_kind  = KIND_CFG_WR;
            req_addr  = ADDR_W'(TCS_ADDR);
            req_wdata = cks_byte;
         end
         PH_TRSP: begin
            req_kind  = KIND_CFG_WR;
            req_addr  = ADDR_W'(TRSP_ADDR);
            req_wdata = 8'(TRSP_FLAG);
         end
         default: ;
      endcase
   end

   assign req_valid = (state == ST_REQ);
   assign rx_clr    = req_valid & req_ready;
   assign rx_active = (state == ST_WAIT);
   assign rx_cap_en = (phase == PH_CAP);
   assign done      = (state == ST_DONE);
   assign err       = (state == ST_FAULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         phase      <= PH_CAP;
         tries      <= '0;
         ext_more   <= 1'b0;
         cks_byte   <= 8'd0;
         link_rate  <= 8'd0;
         lane_count <= 5'd0;
         enh_frame  <= 1'b0;
         err_code   <= FLT_NONE;
      end else begin
         case (state)
            ST_IDLE, ST_DONE, ST_FAULT: begin
               if (start) begin
                  state      <= ST_REQ;
                  phase      <= PH_CAP;
                  tries      <= '0;
                  ext_more   <= 1'b0;
                  link_rate  <= 8'd0;
                  lane_count <= 5'd0;
                  enh_frame  <= 1'b0;
                  err_code   <= FLT_NONE;
               end
            end
            ST_REQ: begin
               if (req_ready) begin
                  state <= ST_WAIT;
                  if (phase == PH_CAP) tries <= tries + TRY_ONE;
               end
            end
            ST_WAIT: begin
               if (xfer_end) begin
                  if (xfer_fail) begin
                     if (phase == PH_CAP && tries < TRY_MAX) begin
                        state <= ST_REQ;
                     end else begin
                        state    <= ST_FAULT;
                        err_code <= FLT_ACCESS;
                     end
                  end else begin
                     case (phase)
                        PH_CAP: state <= ST_EVAL;
                        PH_EXT: begin
                           ext_more <= (rsp_data != 8'd0);
                           phase    <= PH_BLK0;
                           state    <= ST_REQ;
                        end
                        PH_BLK0, PH_BLK1: begin
                           if (sum_next != 8'd0) begin
                              state    <= ST_FAULT;
                              err_code <= FLT_CKSUM;
                           end else begin
                              cks_byte <= rsp_data;
                              phase    <= (phase == PH_BLK0 && ext_more) ? PH_BLK1 : PH_TREQ;
                              state    <= ST_REQ;
                           end
                        end
                        PH_TREQ: begin
                           if (rsp_data[TREQ_BIT]) begin
                              phase <= PH_TCS;
                              state <= ST_REQ;
                           end else begin
                              state <= ST_DONE;
                           end
                        end
                        PH_TCS: begin
                           phase <= PH_TRSP;
                           state <= ST_REQ;
                        end
                        default: state <= ST_DONE;
                     endcase
                  end
               end
            end
            ST_EVAL: begin
               if (dec_fault != FLT_NONE) begin
                  state    <= ST_FAULT;
                  err_code <= dec_fault;
               end else begin
                  link_rate  <= dec_rate;
                  lane_count <= dec_lanes;
                  enh_frame  <= dec_enh;
                  phase      <= PH_EXT;
                  state      <= ST_REQ;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sink_cap_fetch.sv
module sink_cap_fetch
   import sink_cap_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int LEN_W     = 8,
   parameter int CAP_LEN   = 12,
   parameter int CAP_TRIES = 5,
   parameter int BLOCK_LEN = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [1:0]        req_kind,
   output logic [6:0]        req_dev,
   output logic [ADDR_W-1:0] req_addr,
   output logic [LEN_W-1:0]  req_len,
   output logic [7:0]        req_wdata,
   input  logic              rsp_valid,
   input  logic [7:0]        rsp_data,
   input  logic              rsp_fail,
   output logic [7:0]        link_rate,
   output logic [4:0]        lane_count,
   output logic              enh_frame,
   output logic              done,
   output logic              err,
   output logic [2:0]        err_code
);

   localparam int HDR_BYTES = 3;

   if (CAP_TRIES < 1) begin : g_bad_tries
      $error("CAP_TRIES must be at least 1");
   end
   if (CAP_LEN < HDR_BYTES || CAP_LEN >= (1 << LEN_W)) begin : g_bad_cap
      $error("CAP_LEN must cover the header and fit LEN_W");
   end
   if (BLOCK_LEN < 128 || BLOCK_LEN >= (1 << LEN_W)) begin : g_bad_blk
      $error("BLOCK_LEN must be at least 128 and fit LEN_W");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W must reach the test registers");
   end

   acc_kind_t                  kind_w;
   fault_t                     dec_fault, code_w;
   logic [HDR_BYTES-1:0][7:0]  hdr;
   logic [4:0]                 dec_lanes;
   logic                       dec_enh;
   logic                       xfer_end, xfer_fail;
   logic [7:0]                 sum_next;
   logic                       rx_clr, rx_active, rx_cap_en;

   assign req_kind = kind_w;
   assign err_code = code_w;

   sink_cap_rx #(.LEN_W(LEN_W), .HDR_BYTES(HDR_BYTES)) rx_i (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .active(rx_active),
      .cap_en(rx_cap_en), .exp_len(req_len), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_fail(rsp_fail), .xfer_end(xfer_end),
      .xfer_fail(xfer_fail), .sum_next(sum_next), .hdr(hdr)
   );

   sink_cap_decode dec_i (
      .rev_byte(hdr[0]), .rate_byte(hdr[1]), .lane_byte(hdr[2]),
      .fault(dec_fault), .lanes(dec_lanes), .enh(dec_enh)
   );

   sink_cap_seq #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CAP_LEN(CAP_LEN),
      .CAP_TRIES(CAP_TRIES), .BLOCK_LEN(BLOCK_LEN)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(kind_w),
      .req_dev(req_dev), .req_addr(req_addr), .req_len(req_len),
      .req_wdata(req_wdata), .rsp_data(rsp_data), .xfer_end(xfer_end),
      .xfer_fail(xfer_fail), .sum_next(sum_next), .rx_clr(rx_clr),
      .rx_active(rx_active), .rx_cap_en(rx_cap_en), .dec_fault(dec_fault),
      .dec_rate(hdr[1]), .dec_lanes(dec_lanes), .dec_enh(dec_enh),
      .link_rate(link_rate), .lane_count(lane_count), .enh_frame(enh_frame),
      .done(done), .err(err), .err_code(code_w)
   );

endmodule

// File: rtl/sink_cap_chk.sv
module sink_cap_chk #(
   parameter int ADDR_W = 12,
   parameter int LEN_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_kind,
   input logic [ADDR_W-1:0] req_addr,
   input logic [LEN_W-1:0]  req_len,
   input logic [7:0]        req_wdata,
   input logic [7:0]        link_rate,
   input logic [4:0]        lane_count,
   input logic              done,
   input logic              err
);

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_kind) && $stable(req_len) && $stable(req_wdata));

   // R8
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_valid);

   // R9
   status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   // R9
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);

   // R9
   quiet_when_ended_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> !req_valid);

   // R4
   lanes_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lane_count == 5'd1 || lane_count == 5'd2 || lane_count == 5'd4));

   // R3
   rate_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (link_rate == 8'h06 || link_rate == 8'h0A));

endmodule

bind sink_cap_fetch sink_cap_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
   .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
   .req_len(req_len), .req_wdata(req_wdata), .link_rate(link_rate),
   .lane_count(lane_count), .done(done), .err(err)
);

// File: tb/sink_cap_fetch_tb.sv
`timescale 1ns/1ps
module sink_cap_fetch_tb_top;

   localparam int ADDR_W = 12;
   localparam int LEN_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              req_valid, req_ready = 1'b0;
   logic [1:0]        req_kind;
   logic [6:0]        req_dev;
   logic [ADDR_W-1:0] req_addr;
   logic [LEN_W-1:0]  req_len;
   logic [7:0]        req_wdata;
   logic              rsp_valid = 1'b0, rsp_fail = 1'b0;
   logic [7:0]        rsp_data = 8'd0;
   logic [7:0]        link_rate;
   logic [4:0]        lane_count;
   logic              enh_frame, done, err;
   logic [2:0]        err_code;

   always #10 clk = ~clk;

   sink_cap_fetch dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
      .req_ready(req_ready), .req_kind(req_kind), .req_dev(req_dev),
      .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fail(rsp_fail),
      .link_rate(link_rate), .lane_count(lane_count), .enh_frame(enh_frame),
      .done(done), .err(err), .err_code(err_code)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // sink model state
   logic [7:0] cfg_hdr [12];
   logic [7:0] treq_byte;
   logic [7:0] edid [256];
   int         cap_fail_left;
   int         id_fail_addr;
   int         n_req, n_cap, n_blk, n_wr;
   logic [11:0] wr_addr [4];
   logic [7:0]  wr_data [4];
   logic [11:0] ext_addr_seen;
   logic [6:0]  ext_dev_seen;
   logic        blk1_seen;

   logic [1:0]  m_kind;
   logic [11:0] m_addr;
   logic [7:0]  m_len, m_wdata;
   logic [6:0]  m_dev;
   logic        m_fail;

   task automatic chk(input logic cond, input string tag, input int act, input int exp);
      n_checks++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      n_req = 0; n_cap = 0; n_blk = 0; n_wr = 0;
      cap_fail_left = 0; id_fail_addr = -1;
      ext_addr_seen = '0; ext_dev_seen = '0; blk1_seen = 1'b0;
   endtask

   task automatic make_edid(input logic [7:0] ext, input int seed);
      logic [7:0] s0, s1;
      s0 = 8'd0; s1 = 8'd0;
      for (int i = 0; i < 256; i++) edid[i] = 8'(i * 7 + seed);
      edid[126] = ext;
      for (int i = 0; i < 127; i++) s0 = s0 + edid[i];
      for (int i = 128; i < 255; i++) s1 = s1 + edid[i];
      edid[127] = 8'd0 - s0;
      edid[255] = 8'd0 - s1;
   endtask

   task automatic set_hdr(input logic [7:0] rev, input logic [7:0] rate, input logic [7:0] lanes);
      for (int i = 0; i < 12; i++) cfg_hdr[i] = 8'(i + 8'h40);
      cfg_hdr[0] = rev; cfg_hdr[1] = rate; cfg_hdr[2] = lanes;
   endtask

   // responder
   initial begin
      forever begin
         @(negedge clk);
         if (req_valid) begin
            req_ready = 1'b1;
            m_kind = req_kind; m_addr = req_addr; m_len = req_len;
            m_wdata = req_wdata; m_dev = req_dev;
            @(negedge clk);
            req_ready = 1'b0;
            n_req++;
            m_fail = 1'b0;
            if (m_kind == 2'd0 && m_addr == 12'h000) begin
               n_cap++;
               if (cap_fail_left > 0) begin m_fail = 1'b1; cap_fail_left--; end
            end
            if (m_kind == 2'd2 && m_addr == 12'd126) begin
               ext_addr_seen = m_addr; ext_dev_seen = m_dev;
            end
            if (m_kind == 2'd2 && m_len == 8'd128) begin
               n_blk++;
               if (m_addr == 12'd128) blk1_seen = 1'b1;
            end
            if (m_kind == 2'd2 && int'(m_addr) == id_fail_addr) m_fail = 1'b1;
            if (m_kind == 2'd1) begin
               if (n_wr < 4) begin wr_addr[n_wr] = m_addr; wr_data[n_wr] = m_wdata; end
               n_wr++;
            end
            for (int i = 0; i < int'(m_len); i++) begin
               rsp_valid = 1'b1;
               rsp_fail  = m_fail;
               if (m_kind == 2'd2)                 rsp_data = edid[(int'(m_addr) + i) % 256];
               else if (m_kind == 2'd0 && m_addr == 12'h218) rsp_data = treq_byte;
               else if (m_kind == 2'd0)            rsp_data = cfg_hdr[i % 12];
               else                                rsp_data = 8'h00;
               @(negedge clk);
               if (m_fail) break;
            end
            rsp_valid = 1'b0;
            rsp_fail  = 1'b0;
         end
      end
   end

   task automatic run_seq(output logic ended);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      ended = 1'b0;
      for (int c = 0; c < 5000; c++) begin
         @(negedge clk);
         if (done || err) begin ended = 1'b1; break; end
      end
      chk(ended, "R9 sequence ended", 0, 1);
   endtask

   task automatic t_reset();
      chk(done == 0 && err == 0, "R1 status after reset", {done, err}, 0);
      chk(err_code == 0 && req_valid == 0, "R1 code/req after reset", {err_code, req_valid}, 0);
      chk(link_rate == 0 && lane_count == 0 && enh_frame == 0, "R1 link outputs after reset",
          {link_rate, lane_count, enh_frame}, 0);
   endtask

   task automatic t_basic_new_rev();
      logic e;
      model_clear(); set_hdr(8'h11, 8'h0A, 8'h84); make_edid(8'h00, 3); treq_byte = 8'h04;
      run_seq(e);
      chk(done == 1 && err == 0, "R7 done after echo", {done, err}, 2);
      chk(lane_count == 4 && enh_frame == 1, "R4 rev11 lanes/enh", {lane_count, enh_frame}, 9);
      chk(link_rate == 8'h0A, "R3 rate accepted", link_rate, 8'h0A);
      chk(ext_addr_seen == 12'd126 && ext_dev_seen == 7'h50, "R5 ext byte request",
          {ext_dev_seen, ext_addr_seen}, {7'h50, 12'd126});
      chk(n_blk == 1 && n_req == 6, "R5 one block fetched", n_blk * 16 + n_req, 22);
      chk(n_wr == 2 && wr_addr[0] == 12'h261 && wr_data[0] == edid[127], "R7 checksum echo",
          {wr_addr[0], wr_data[0]}, {12'h261, edid[127]});
      chk(wr_addr[1] == 12'h260 && wr_data[1] == 8'h04, "R7 response flag",
          {wr_addr[1], wr_data[1]}, {12'h260, 8'h04});
      chk(n_cap == 1, "R2 single header read", n_cap, 1);
      repeat (10) @(negedge clk);
      chk(done == 1 && req_valid == 0, "R9 done holds", {done, req_valid}, 2);
   endtask

   task automatic t_old_rev_two_blocks();
      logic e;
      model_clear(); set_hdr(8'h10, 8'h06, 8'h02); make_edid(8'h01, 11); treq_byte = 8'hFB;
      run_seq(e);
      chk(done == 1, "R5 two-block run done", done, 1);
      chk(lane_count == 2 && enh_frame == 0, "R4 rev10 lanes/enh", {lane_count, enh_frame}, 4);
      chk(link_rate == 8'h06, "R3 low rate accepted", link_rate, 8'h06);
      chk(n_blk == 2 && blk1_seen, "R5 second block at 128", {n_blk, blk1_seen}, 5);
      chk(n_wr == 0, "R7 no write when bit2 clear", n_wr, 0);
   endtask

   task automatic t_second_block_echo();
      logic e;
      model_clear(); set_hdr(8'h11, 8'h06, 8'h01); make_edid(8'h02, 29); treq_byte = 8'h04;
      run_seq(e);
      chk(done == 1 && n_wr == 2 && wr_data[0] == edid[255], "R7 echo of last block",
          wr_data[0], edid[255]);
   endtask

   task automatic t_header_faults();
      logic e;
      model_clear(); set_hdr(8'h10, 8'h0A, 8'h84); make_edid(8'h00, 1); treq_byte = 8'h00;
      run_seq(e);
      chk(err == 1 && err_code == 3'd4, "R4 rev10 whole byte lanes", err_code, 4);
      chk(n_req == 1, "R4 no further requests", n_req, 1);
      model_clear(); set_hdr(8'h11, 8'h0A, 8'h83);
      run_seq(e);
      chk(err == 1 && err_code == 3'd4, "R4 three lanes rejected", err_code, 4);
      model_clear(); set_hdr(8'h12, 8'h0A, 8'h84);
      run_seq(e);
      chk(err == 1 && err_code == 3'd2, "R3 bad revision", err_code, 2);
      model_clear(); set_hdr(8'h11, 8'h14, 8'h84);
      run_seq(e);
      chk(err == 1 && err_code == 3'd3, "R3 bad rate", err_code, 3);
      model_clear(); set_hdr(8'h20, 8'h14, 8'h03);
      run_seq(e);
      chk(err_code == 3'd2, "R3 revision checked first", err_code, 2);
      chk(link_rate == 0 && lane_count == 0, "R9 outputs cleared at start", {link_rate, lane_count}, 0);
   endtask

   task automatic t_checksum();
      logic e;
      model_clear(); set_hdr(8'h11, 8'h0A, 8'h82); make_edid(8'h01, 5); treq_byte = 8'h04;
      edid[200] = edid[200] + 8'd1;
      run_seq(e);
      chk(err == 1 && err_code == 3'd5, "R6 second block checksum", err_code, 5);
      chk(n_wr == 0, "R6 no echo after bad block", n_wr, 0);
      model_clear(); make_edid(8'h00, 9); edid[10] = edid[10] ^ 8'h20;
      run_seq(e);
      chk(err == 1 && err_code == 3'd5, "R6 first block checksum", err_code, 5);
   endtask

   task automatic t_retry();
      logic e;
      model_clear(); set_hdr(8'h11, 8'h0A, 8'h84); make_edid(8'h00, 2); treq_byte = 8'h00;
      cap_fail_left = 4;
      run_seq(e);
      chk(done == 1 && n_cap == 5, "R2 success on fifth attempt", n_cap, 5);
      model_clear(); cap_fail_left = 5;
      run_seq(e);
      chk(err == 1 && err_code == 3'd1, "R2 all attempts failed", err_code, 1);
      chk(n_cap == 5 && n_req == 5, "R2 attempt count bounded", n_cap, 5);
      model_clear(); id_fail_addr = 0;
      run_seq(e);
      chk(err == 1 && err_code == 3'd1, "R6 block access failure", err_code, 1);
   endtask

   task automatic t_busy_start();
      logic ended;
      model_clear(); set_hdr(8'h11, 8'h0A, 8'h84); make_edid(8'h00, 7); treq_byte = 8'h04;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      ended = 1'b0;
      for (int c = 0; c < 5000; c++) begin
         @(negedge clk);
         if (done || err) begin ended = 1'b1; break; end
      end
      chk(ended && done, "R9 run completes", done, 1);
      chk(n_cap == 1 && n_req == 6, "R9 start ignored while busy", n_req, 6);
   endtask

   logic finished = 1'b0;

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_basic_new_rev();
      t_old_rev_two_blocks();
      t_second_block_echo();
      t_header_faults();
      t_checksum();
      t_retry();
      t_busy_start();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog R9: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule